// File: doc/BRIEF.md
# PCM Serial Port with Frame-Type Detection

This block runs one voice channel's serial PCM link at the bit-clock level. A frame starts on the first rising edge of the bit clock that finds the frame sync high. From that edge the transmit word goes out MSB first, one bit per rising edge, with a separate output-enable pin that drives an external tri-state buffer. The receive word is shifted in MSB first on falling edges. When its last bit is in, the word is presented together with a one-cycle valid pulse.

The bit clock, frame sync and receive data are sampled by a faster system clock, and edges are detected from those samples. The word is 8 bits in companded mode and 14 bits in linear mode. The mode is taken when the frame starts. On every frame the block counts the bit-clock falling edges during which the sync stays high. One such edge marks a short-sync frame. Two or more mark a long-sync frame, and a long sync that outlasts the word keeps the output driven until the sync drops. Bit clocks after the word are ignored. A power-down input abandons the frame in progress.

Top module: `pcm_sport`

## Requirements
- R1: After reset, sdo_oe, rx_valid and frame_long are all 0.
- R2: The transmit word is sent MSB first. sdo carries bit k of the word from the k-th rising bit-clock edge of the frame. In linear mode (lin_mode=1) the word is tx_word[13:0]. In companded mode (lin_mode=0) it is tx_word[7:0].
- R3: Receive bit k is taken from sdi on the k-th falling bit-clock edge of the frame, MSB first. rx_word holds the word right-justified, and its bits 13:8 are zero in companded mode.
- R4: rx_valid is a pulse of exactly one system-clock cycle, given once per complete frame, shortly after the falling edge that captures the last bit.
- R5: sdo_oe rises on a rising bit-clock edge that finds frame sync high, provided that no frame is in progress and that frame sync has been low since the previous frame started.
- R6: When frame sync is already low at the falling edge that ends the last bit (the 8th or the 14th), sdo_oe drops at that edge, which gives 7.5 or 13.5 bit periods of drive.
- R7: When frame sync has been high at every falling edge of the frame up to and including the last one, sdo_oe stays high until frame sync goes low.
- R8: When each frame's sync ends, frame_long is set to 1 if two or more falling edges were seen with sync high, and to 0 if only one was seen. It is re-evaluated every frame.
- R9: Bit clocks after the word with frame sync low produce no rx_valid and leave sdo_oe low.
- R10: While pwr_dn is 1, sdo_oe is forced low and the frame in progress is dropped without an rx_valid. The next frame after release behaves normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_dn | input | 1 | Power down: abandons the frame and releases the output |
| lin_mode | input | 1 | 1 selects the 14-bit linear word, 0 the 8-bit companded word |
| bclk | input | 1 | Serial bit clock |
| fsync | input | 1 | Frame sync |
| sdi | input | 1 | Serial receive data |
| tx_word | input | 14 | Word to transmit, taken when the frame starts |
| sdo | output | 1 | Serial transmit data |
| sdo_oe | output | 1 | Output enable for the external tri-state buffer |
| rx_word | output | 14 | Last received word |
| rx_valid | output | 1 | One-cycle pulse when rx_word is updated |
| frame_long | output | 1 | Sync type of the most recent frame (1 = long) |

## Verification
The bench goes after the release point of the output. In a short frame and in a long frame whose sync drops early, the output must stop driving half a bit after the last bit. A design that ignored the frame type would either cut off a long sync that is still held or keep driving into the next channel's slot. The bench alternates sync widths from one frame to the next, so a design that fixes the frame type on the first frame would report a stale frame_long. It adds clocks after the word, which catch a bit counter that wraps and sends a second valid pulse. It also asserts power-down in the middle of a frame, which exposes a receiver that still reports a half-received word.

// File: rtl/pcm_sport_pkg.sv
package pcm_sport_pkg;

    typedef struct packed {
        logic rise;
        logic fall;
        logic fs;
        logic sd;
    } pin_evt_t;

    localparam int unsigned SYNC_CNT_W = 2;

    function automatic logic [SYNC_CNT_W-1:0] sat_inc(input logic [SYNC_CNT_W-1:0] v);
        return (v == '1) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/pcm_sport_edge.sv
module pcm_sport_edge
    import pcm_sport_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bclk,
    input  logic     fsync,
    input  logic     sdi,
    output pin_evt_t evt
);
    typedef struct packed {
        logic bclk_s;
        logic bclk_p;
        logic fs_s;
        logic sd_s;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d        = smp_q;
        smp_d.bclk_s = bclk;
        smp_d.bclk_p = smp_q.bclk_s;
        smp_d.fs_s   = fsync;
        smp_d.sd_s   = sdi;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign evt.rise = smp_q.bclk_s & ~smp_q.bclk_p;
    assign evt.fall = ~smp_q.bclk_s & smp_q.bclk_p;
    assign evt.fs   = smp_q.fs_s;
    assign evt.sd   = smp_q.sd_s;

endmodule

// File: rtl/pcm_sport_rx.sv
module pcm_sport_rx #(
    parameter int unsigned LONG_W  = 14,
    parameter int unsigned SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd,
    input  logic              start,
    input  logic              lin_in,
    input  logic              fall,
    input  logic              sd,
    output logic [LONG_W-1:0] word,
    output logic              valid
);
    localparam int unsigned CW = $clog2(LONG_W + 1);
    localparam logic [CW-1:0] N_LONG  = CW'(LONG_W);
    localparam logic [CW-1:0] N_SHORT = CW'(SHORT_W);

    typedef struct packed {
        logic              busy;
        logic              lin;
        logic [CW-1:0]     cnt;
        logic [LONG_W-1:0] sh;
        logic [LONG_W-1:0] word;
        logic              valid;
    } rx_t;

    rx_t rx_d, rx_q;
    logic [CW-1:0]     n_bits;
    logic [LONG_W-1:0] sh_next;

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        n_bits     = rx_q.lin ? N_LONG : N_SHORT;
        sh_next    = {rx_q.sh[LONG_W-2:0], sd};
        if (pd) begin
            rx_d.busy = 1'b0;
            rx_d.cnt  = '0;
        end else if (start) begin
            rx_d.busy = 1'b1;
            rx_d.lin  = lin_in;
            rx_d.cnt  = '0;
            rx_d.sh   = '0;
        end else if (fall && rx_q.busy) begin
            rx_d.sh  = sh_next;
            rx_d.cnt = rx_q.cnt + 1'b1;
            if (rx_q.cnt + 1'b1 == n_bits) begin
                rx_d.busy  = 1'b0;
                rx_d.valid = 1'b1;
                if (rx_q.lin) rx_d.word = sh_next;
                else          rx_d.word = {{(LONG_W-SHORT_W){1'b0}}, sh_next[SHORT_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign word  = rx_q.word;
    assign valid = rx_q.valid;

endmodule

// File: rtl/pcm_sport.sv
module pcm_sport
    import pcm_sport_pkg::*;
#(
    parameter int unsigned LONG_W  = 14,
    parameter int unsigned SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn,
    input  logic              lin_mode,
    input  logic              bclk,
    input  logic              fsync,
    input  logic              sdi,
    input  logic [LONG_W-1:0] tx_word,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [LONG_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              frame_long
);
    localparam int unsigned CW = $clog2(LONG_W + 1);
    localparam logic [CW-1:0] N_LONG  = CW'(LONG_W);
    localparam logic [CW-1:0] N_SHORT = CW'(SHORT_W);
    localparam int unsigned PAD = LONG_W - SHORT_W;

    pin_evt_t evt;
    logic     bclk_rise, bclk_fall, fs_smp;
    logic     start;

    pcm_sport_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .bclk  (bclk),
        .fsync (fsync),
        .sdi   (sdi),
        .evt   (evt)
    );

    assign bclk_rise = evt.rise;
    assign bclk_fall = evt.fall;
    assign fs_smp    = evt.fs;

    typedef struct packed {
        logic                  armed;
        logic                  active;
        logic                  hold;
        logic                  syncing;
        logic                  lin;
        logic                  oe;
        logic                  flong;
        logic [SYNC_CNT_W-1:0] width;
        logic [CW-1:0]         cnt;
        logic [LONG_W-1:0]     sh;
    } ctl_t;

    ctl_t c_d, c_q;
    logic [CW-1:0]         n_bits;
    logic [SYNC_CNT_W-1:0] width_n;

    assign start = bclk_rise && fs_smp && c_q.armed && !c_q.active && !c_q.hold && !pwr_dn;

    always_comb begin
        c_d     = c_q;
        n_bits  = c_q.lin ? N_LONG : N_SHORT;
        width_n = c_q.width;

        if (!fs_smp) c_d.armed = 1'b1;

        if (c_q.syncing && bclk_fall && fs_smp) begin
            width_n   = sat_inc(c_q.width);
            c_d.width = width_n;
        end
        if (c_q.syncing && !fs_smp) begin
            c_d.syncing = 1'b0;
            c_d.flong   = (c_q.width >= 2);
        end

        if (pwr_dn) begin
            c_d.active  = 1'b0;
            c_d.hold    = 1'b0;
            c_d.syncing = 1'b0;
            c_d.oe      = 1'b0;
            c_d.cnt     = '0;
            c_d.width   = '0;
        end else if (start) begin
            c_d.armed   = 1'b0;
            c_d.active  = 1'b1;
            c_d.syncing = 1'b1;
            c_d.width   = '0;
            c_d.lin     = lin_mode;
            c_d.oe      = 1'b1;
            c_d.cnt     = CW'(1);
            c_d.sh      = lin_mode ? tx_word : {tx_word[SHORT_W-1:0], {PAD{1'b0}}};
        end else begin
            if (c_q.active && bclk_rise && c_q.cnt < n_bits) begin
                c_d.sh  = {c_q.sh[LONG_W-2:0], 1'b0};
                c_d.cnt = c_q.cnt + 1'b1;
            end
            if (c_q.active && bclk_fall && c_q.cnt == n_bits) begin
                c_d.active = 1'b0;
                if (c_q.syncing && fs_smp && width_n >= 2) c_d.hold = 1'b1;
                else                                       c_d.oe   = 1'b0;
            end
            if (c_q.hold && !fs_smp) begin
                c_d.hold = 1'b0;
                c_d.oe   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    pcm_sport_rx #(
        .LONG_W  (LONG_W),
        .SHORT_W (SHORT_W)
    ) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .pd     (pwr_dn),
        .start  (start),
        .lin_in (lin_mode),
        .fall   (bclk_fall),
        .sd     (evt.sd),
        .word   (rx_word),
        .valid  (rx_valid)
    );

    assign sdo        = c_q.sh[LONG_W-1];
    assign sdo_oe     = c_q.oe;
    assign frame_long = c_q.flong;

endmodule

// File: rtl/pcm_sport_chk.sv
module pcm_sport_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_dn,
    input logic sdo,
    input logic sdo_oe,
    input logic rx_valid,
    input logic rise_w,
    input logic fall_w,
    input logic fs_w
);
    // R10: power down releases the output on the next cycle
    assert_pd_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> !sdo_oe);

    // R10: no received word is reported during power down
    assert_pd_no_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> !rx_valid);

    // R4: valid is a single-cycle pulse
    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R3: a word completes only on a falling bit-clock edge
    assert_valid_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(fall_w));

    // R5: drive starts only on a rising edge with sync high
    assert_oe_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> ($past(rise_w) && $past(fs_w)));

    // R2: transmit data moves only on rising edges
    assert_sdo_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $past(rise_w));
endmodule

bind pcm_sport pcm_sport_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_dn   (pwr_dn),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .rx_valid (rx_valid),
    .rise_w   (bclk_rise),
    .fall_w   (bclk_fall),
    .fs_w     (fs_smp)
);

// File: tb/pcm_sport_bench.sv
module pcm_sport_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_dn = 1'b0;
    logic        lin_mode = 1'b0;
    logic        bclk = 1'b0;
    logic        fsync = 1'b0;
    logic        sdi = 1'b0;
    logic [13:0] tx_word = '0;
    logic        sdo, sdo_oe, rx_valid, frame_long;
    logic [13:0] rx_word;

    int total = 0;
    int bad = 0;
    logic [13:0] exp_q[$];
    logic prev_valid = 1'b0;

    localparam int HALF = 6;

    always #2.5 clk = ~clk;

    pcm_sport u_pcm_sport (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .lin_mode(lin_mode),
        .bclk(bclk), .fsync(fsync), .sdi(sdi), .tx_word(tx_word),
        .sdo(sdo), .sdo_oe(sdo_oe), .rx_word(rx_word), .rx_valid(rx_valid),
        .frame_long(frame_long)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expected received words (R3, R4, R9, R10)
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid && prev_valid)
                check(1'b0, "R4 pulse longer than one cycle", 1, 0);
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9/R10 unexpected rx_valid", 32'(rx_word), 0);
                end else begin
                    logic [13:0] e;
                    e = exp_q.pop_front();
                    check(rx_word == e, "R3 received word", 32'(rx_word), 32'(e));
                end
            end
            prev_valid <= rx_valid;
        end
    end

    // driver: one frame; nfs = falling edges with sync high, extra = bits after the word
    task automatic frame(input bit lin, input int nfs, input logic [13:0] txw,
                         input logic [13:0] rxw, input int extra);
        int n;
        logic [13:0] rx_exp;
        n = lin ? 14 : 8;
        rx_exp = lin ? rxw : {6'b0, rxw[7:0]};
        exp_q.push_back(rx_exp);
        lin_mode = lin;
        tx_word  = txw;
        fsync    = 1'b1;
        wait_clk(HALF);
        for (int k = 1; k <= n + extra; k++) begin
            bclk = 1'b1;
            sdi  = (k <= n) ? rx_exp[n-k] : ~sdi;
            wait_clk(HALF);
            if (k <= n) begin
                logic eb;
                eb = lin ? txw[14-k] : txw[8-k];
                check(sdo_oe == 1'b1, k == 1 ? "R5 drive starts at first rise" : "R2 drive held during word",
                      32'(sdo_oe), 1);
                check(sdo == eb, "R2 transmit bit", 32'(sdo), 32'(eb));
            end
            bclk = 1'b0;
            wait_clk(HALF/2);
            if (k == nfs) fsync = 1'b0;
            wait_clk(HALF - HALF/2);
            if (k == n) begin
                check(sdo_oe == (nfs > n), nfs > n ? "R7 long sync holds drive" : "R6 release after last bit",
                      32'(sdo_oe), 32'(nfs > n));
            end else if (k > n) begin
                check(sdo_oe == (nfs > k), "R9 extra clocks leave output", 32'(sdo_oe), 32'(nfs > k));
            end
        end
        fsync = 1'b0;
        wait_clk(2 * HALF);
        check(sdo_oe == 1'b0, "R6 released after frame", 32'(sdo_oe), 0);
        check(frame_long == (nfs >= 2), "R8 frame type", 32'(frame_long), 32'(nfs >= 2));
        check(exp_q.size() == 0, "R4 word reported once", 32'(exp_q.size()), 0);
    endtask

    task automatic pd_frame();
        lin_mode = 1'b0;
        tx_word  = 14'h0A5;
        fsync    = 1'b1;
        wait_clk(HALF);
        for (int k = 1; k <= 8; k++) begin
            bclk = 1'b1;
            sdi  = k[0];
            wait_clk(HALF);
            if (k == 3) begin
                pwr_dn = 1'b1;
                wait_clk(2);
                check(sdo_oe == 1'b0, "R10 power down releases output", 32'(sdo_oe), 0);
            end
            bclk = 1'b0;
            wait_clk(HALF/2);
            if (k == 1) fsync = 1'b0;
            wait_clk(HALF - HALF/2);
        end
        check(sdo_oe == 1'b0, "R10 output stays released", 32'(sdo_oe), 0);
        wait_clk(HALF);
        pwr_dn = 1'b0;
        wait_clk(2 * HALF);
        check(exp_q.size() == 0 && sdo_oe == 1'b0, "R10 no word for dropped frame", 32'(sdo_oe), 0);
    endtask

    initial begin
        wait_clk(5);
        check(sdo_oe == 1'b0, "R1 reset oe", 32'(sdo_oe), 0);
        check(rx_valid == 1'b0, "R1 reset valid", 32'(rx_valid), 0);
        check(frame_long == 1'b0, "R1 reset frame type", 32'(frame_long), 0);
        rst_n = 1'b1;
        wait_clk(4);
        frame(1'b0, 1, 14'h0096, 14'h00C3, 0);   // short, 8-bit
        frame(1'b0, 3, 14'h005A, 14'h0081, 0);   // long, 8-bit
        frame(1'b1, 1, 14'h2D3C, 14'h1A5F, 0);   // short, 14-bit
        frame(1'b1, 2, 14'h3001, 14'h2AAA, 0);   // long, 14-bit
        frame(1'b0, 11, 14'h00FF, 14'h0001, 4);  // long sync outlasting word
        frame(1'b0, 1, 14'h3F80, 14'h3F7E, 3);   // short with extra clocks, top bits ignored
        frame(1'b1, 5, 14'h1555, 14'h0F0F, 2);   // long, extra clocks
        pd_frame();
        frame(1'b0, 1, 14'h0033, 14'h00E7, 0);   // normal after power down
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule